// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a byte-wide configuration space that a host reaches through two ports: an index port that names a register and a data port that moves the register's contents. The space stays closed until the host writes an unlock key to the index port on two index writes in a row. A separate lock key closes it again. While the space is closed, every read returns 0xFF and data writes have no effect.

Once the space is open, a device-select register picks which per-device bank the data port reaches. Each bank holds an activate bit, a 16-bit I/O base address split into a high byte and a low byte, and an interrupt-line number. The contents of every bank drive the block's outputs (per-device enable, base and interrupt line) all the time. Two read-only identity bytes and the device selector are global registers and can be reached whatever device is selected.

The unlock logic is a three-state machine. LOCKED moves to ARMED on an index write of the unlock key. ARMED moves to OPEN on a second unlock-key index write and falls back to LOCKED on any other index write. OPEN moves to LOCKED on an index write of the lock key. Every other index write in OPEN loads the register number. Data-port writes and all reads never change the state.

Top module: `cfgp_port`

## Requirements
- R1: After reset the space is LOCKED, both ports read 0xFF, and all enable, base and interrupt outputs are 0.
- R2: Only two consecutive index writes of the unlock key (default 0x87) open the space; after a single one, reads still return 0xFF.
- R3: An index write of any value other than the unlock key, made between the two key writes, restarts the sequence, so two further key writes are needed.
- R4: An index write of the lock key (default 0xAA) while OPEN closes the space; while not OPEN all reads return 0xFF and data writes change no register or output.
- R5: While OPEN, an index write stores the register number, the index port reads it back, and the data port reads or writes the numbered register.
- R6: Writing register 0x07 selects a device; bank writes reach only the selected device's bank and outputs.
- R7: Bit 0 of a write to register 0x30 sets or clears the selected device's enable output; the register reads back as that bit in bit 0 with zeros above.
- R8: Registers 0x60 and 0x61 hold bits 15:8 and 7:0 of the selected device's base output; register 0x70 keeps the low IRQ_W bits of the written byte as the interrupt output and reads them back zero-extended.
- R9: Registers 0x20 and 0x21 read the high and low identity bytes (default 0xC5, 0xB3), and writes to them are ignored.
- R10: When the selected device number is NUM_DEV or more, bank registers read 0xFF and writes to them change no output.
- R11: A register number that names no register reads 0xFF.
- R12: The selector and the identity bytes read correctly whatever device number is selected, in range or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 1 | Port select: 0 index port, 1 data port |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte of the port chosen by host_addr (combinational) |
| dev_en | output | NUM_DEV | Per-device enable |
| dev_base | output | 16*NUM_DEV | Per-device I/O base, device i at bits 16i+15:16i |
| dev_irq | output | IRQ_W*NUM_DEV | Per-device interrupt-line number |

## Verification
A fault in the unlock state machine shows up in the first read after the offending index write. The read returns 0xFF where register data was due, or real data where 0xFF was due. A wrong index or selector register appears in the same way, on the next data-port read, as the wrong byte. Bank writes that reach the wrong device change that device's outputs one clock after the write strobe. The bench compares all outputs after every operation, so such a misdirected write is caught before the next operation.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } lock_state_t;

    localparam logic [7:0] REG_DEVSEL = 8'h07;
    localparam logic [7:0] REG_IDHI   = 8'h20;
    localparam logic [7:0] REG_IDLO   = 8'h21;
    localparam logic [7:0] REG_ACT    = 8'h30;
    localparam logic [7:0] REG_BASEHI = 8'h60;
    localparam logic [7:0] REG_BASELO = 8'h61;
    localparam logic [7:0] REG_IRQ    = 8'h70;

endpackage

// File: rtl/cfgp_unlock_fsm.sv
module cfgp_unlock_fsm
    import cfgp_pkg::*;
#(
    parameter logic [7:0] KEY_ON  = 8'h87,
    parameter logic [7:0] KEY_OFF = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic       idx_load
);

    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (idx_wr && wdata == KEY_ON) state_d = ST_ARMED;
            ST_ARMED:  if (idx_wr) state_d = (wdata == KEY_ON) ? ST_OPEN : ST_LOCKED;
            ST_OPEN:   if (idx_wr && wdata == KEY_OFF) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        unlocked = (state_q == ST_OPEN);
        idx_load = (state_q == ST_OPEN) && idx_wr && (wdata != KEY_OFF);
    end

endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
    import cfgp_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       reg_num,
    input  logic [7:0]       wdata,
    output logic             en,
    output logic [15:0]      base,
    output logic [IRQ_W-1:0] irq,
    output logic [7:0]       rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en   <= 1'b0;
            base <= '0;
            irq  <= '0;
        end else if (wr) begin
            case (reg_num)
                REG_ACT:    en          <= wdata[0];
                REG_BASEHI: base[15:8]  <= wdata;
                REG_BASELO: base[7:0]   <= wdata;
                REG_IRQ:    irq         <= wdata[IRQ_W-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (reg_num)
            REG_ACT:    rd_data = {7'b0, en};
            REG_BASEHI: rd_data = base[15:8];
            REG_BASELO: rd_data = base[7:0];
            REG_IRQ:    rd_data = 8'(irq);
            default:    rd_data = 8'hFF;
        endcase
    end

endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int          NUM_DEV = 4,
    parameter int          IRQ_W   = 4,
    parameter logic [7:0]  KEY_ON  = 8'h87,
    parameter logic [7:0]  KEY_OFF = 8'hAA,
    parameter logic [15:0] CHIP_ID = 16'hC5B3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_addr,
    input  logic                     host_wr,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    output logic [NUM_DEV-1:0]       dev_en,
    output logic [16*NUM_DEV-1:0]    dev_base,
    output logic [IRQ_W*NUM_DEV-1:0] dev_irq
);

    localparam logic [7:0] DEV_LIMIT = 8'(NUM_DEV);

    logic       unlocked, idx_load, idx_wr, dat_wr;
    logic [7:0] idx_q, sel_q, sel_rd;
    logic [7:0] bank_rd [NUM_DEV];

    assign idx_wr = host_wr && !host_addr;
    assign dat_wr = host_wr && host_addr && unlocked;

    cfgp_unlock_fsm #(.KEY_ON(KEY_ON), .KEY_OFF(KEY_OFF)) u_fsm (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(host_wdata),
        .unlocked(unlocked), .idx_load(idx_load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            sel_q <= '0;
        end else begin
            if (idx_load) idx_q <= host_wdata;
            if (dat_wr && idx_q == REG_DEVSEL) sel_q <= host_wdata;
        end
    end

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
        cfgp_dev_bank #(.IRQ_W(IRQ_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr(dat_wr && sel_q == 8'(i)),
            .reg_num(idx_q), .wdata(host_wdata),
            .en(dev_en[i]),
            .base(dev_base[16*i +: 16]),
            .irq(dev_irq[IRQ_W*i +: IRQ_W]),
            .rd_data(bank_rd[i])
        );
    end

    always_comb begin
        sel_rd = 8'hFF;
        if (sel_q < DEV_LIMIT) begin
            for (int i = 0; i < NUM_DEV; i++)
                if (sel_q == 8'(i)) sel_rd = bank_rd[i];
        end
    end

    always_comb begin
        if (!unlocked)      host_rdata = 8'hFF;
        else if (!host_addr) host_rdata = idx_q;
        else begin
            case (idx_q)
                REG_DEVSEL: host_rdata = sel_q;
                REG_IDHI:   host_rdata = CHIP_ID[15:8];
                REG_IDLO:   host_rdata = CHIP_ID[7:0];
                default:    host_rdata = sel_rd;
            endcase
        end
    end

endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk #(
    parameter int          NUM_DEV = 4,
    parameter int          IRQ_W   = 4,
    parameter logic [7:0]  KEY_ON  = 8'h87,
    parameter logic [7:0]  KEY_OFF = 8'hAA
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     host_addr,
    input logic                     host_wr,
    input logic [7:0]               host_wdata,
    input logic [7:0]               host_rdata,
    input logic                     unlocked,
    input logic [7:0]               sel_q,
    input logic [7:0]               idx_q,
    input logic [NUM_DEV-1:0]       dev_en,
    input logic [16*NUM_DEV-1:0]    dev_base,
    input logic [IRQ_W*NUM_DEV-1:0] dev_irq
);

    // R4
    locked_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> host_rdata == 8'hFF);

    // R2
    unlock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && host_wr && !host_addr && host_wdata != KEY_ON) |=> !unlocked);

    // R4
    lock_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && host_wr && !host_addr && host_wdata == KEY_OFF) |=> !unlocked);

    // R4
    locked_outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(dev_en) && $stable(dev_base) && $stable(dev_irq)));

    // R10
    bad_sel_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q >= 8'(NUM_DEV)) |=> ($stable(dev_en) && $stable(dev_base) && $stable(dev_irq)));

    // R7
    act_write_dev0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && host_wr && host_addr && idx_q == 8'h30 && sel_q == 8'd0)
        |=> dev_en[0] == $past(host_wdata[0]));

endmodule

bind cfgp_port cfgp_port_chk #(
    .NUM_DEV(NUM_DEV), .IRQ_W(IRQ_W), .KEY_ON(KEY_ON), .KEY_OFF(KEY_OFF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .unlocked(unlocked),
    .sel_q(sel_q), .idx_q(idx_q), .dev_en(dev_en), .dev_base(dev_base),
    .dev_irq(dev_irq)
);

// File: tb/tb_cfgp_port.sv
module tb_cfgp_port;

    localparam int CLK_PERIOD = 10;
    localparam int ND = 4;
    localparam int IW = 4;
    localparam logic [7:0] K_ON = 8'h87;
    localparam logic [7:0] K_OFF = 8'hAA;

    logic clk = 0, rst_n = 0;
    logic host_addr = 0, host_wr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic [ND-1:0] dev_en;
    logic [16*ND-1:0] dev_base;
    logic [IW*ND-1:0] dev_irq;

    int checks = 0, errors = 0;

    // model: 0 locked, 1 armed, 2 open
    int m_state = 0;
    logic [7:0] m_idx = 0, m_sel = 0;
    logic m_en [ND];
    logic [15:0] m_base [ND];
    logic [IW-1:0] m_irq [ND];

    cfgp_port dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_wr(input logic a, input logic [7:0] v);
        if (!a) begin
            case (m_state)
                0: if (v == K_ON) m_state = 1;
                1: m_state = (v == K_ON) ? 2 : 0;
                default: if (v == K_OFF) m_state = 0; else m_idx = v;
            endcase
        end else if (m_state == 2) begin
            if (m_idx == 8'h07) m_sel = v;
            else if (m_sel < ND) begin
                case (m_idx)
                    8'h30: m_en[m_sel] = v[0];
                    8'h60: m_base[m_sel][15:8] = v;
                    8'h61: m_base[m_sel][7:0] = v;
                    8'h70: m_irq[m_sel] = v[IW-1:0];
                    default: ;
                endcase
            end
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic a);
        if (m_state != 2) return 8'hFF;
        if (!a) return m_idx;
        case (m_idx)
            8'h07: return m_sel;
            8'h20: return 8'hC5;
            8'h21: return 8'hB3;
            8'h30: return (m_sel < ND) ? {7'b0, m_en[m_sel]} : 8'hFF;
            8'h60: return (m_sel < ND) ? m_base[m_sel][15:8] : 8'hFF;
            8'h61: return (m_sel < ND) ? m_base[m_sel][7:0] : 8'hFF;
            8'h70: return (m_sel < ND) ? 8'(m_irq[m_sel]) : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic bus_wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_wr = 1; host_wdata = v;
        @(negedge clk);
        host_wr = 0;
        model_wr(a, v);
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic chk_rd(input string tag, input logic a);
        logic [7:0] v;
        bus_rd(a, v);
        chk(tag, v, exp_rd(a));
    endtask

    task automatic chk_outs(input string tag);
        for (int i = 0; i < ND; i++) begin
            chk({tag, " en"}, dev_en[i], m_en[i]);
            chk({tag, " base"}, dev_base[16*i +: 16], m_base[i]);
            chk({tag, " irq"}, dev_irq[IW*i +: IW], m_irq[i]);
        end
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] picks [10];
        picks = '{K_ON, K_ON, K_OFF, 8'h07, 8'h20, 8'h30, 8'h60, 8'h61, 8'h70, 8'h55};
        void'($urandom(32'd4242));
        for (int i = 0; i < ND; i++) begin m_en[i] = 0; m_base[i] = 0; m_irq[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        bus_rd(0, v); chk("R1 index port", v, 8'hFF);
        bus_rd(1, v); chk("R1 data port", v, 8'hFF);
        chk("R1 en", dev_en, 0); chk("R1 base", dev_base, 0); chk("R1 irq", dev_irq, 0);

        // R2 single key stays locked
        bus_wr(0, K_ON);
        bus_rd(1, v); chk("R2 one key", v, 8'hFF);
        // R3 other index write restarts sequence
        bus_wr(0, 8'h20);
        bus_wr(0, K_ON);
        bus_rd(0, v); chk("R3 restarted", v, 8'hFF);
        bus_wr(0, K_ON);
        bus_rd(0, v); chk("R2 open after two keys", v, 8'h00);

        // R5 / R9 identity bytes
        bus_wr(0, 8'h20);
        bus_rd(0, v); chk("R5 index readback", v, 8'h20);
        bus_rd(1, v); chk("R9 id hi", v, 8'hC5);
        bus_wr(1, 8'h00);
        bus_rd(1, v); chk("R9 id hi after write", v, 8'hC5);
        bus_wr(0, 8'h21);
        bus_rd(1, v); chk("R9 id lo", v, 8'hB3);

        // R6 / R8 device 1 base and irq
        bus_wr(0, 8'h07); bus_wr(1, 8'h01);
        bus_wr(0, 8'h60); bus_wr(1, 8'h03);
        bus_wr(0, 8'h61); bus_wr(1, 8'hF8);
        chk("R8 base dev1", dev_base[31:16], 16'h03F8);
        chk("R6 base dev0 untouched", dev_base[15:0], 16'h0000);
        bus_wr(0, 8'h70); bus_wr(1, 8'hF3);
        chk("R8 irq dev1", dev_irq[7:4], 4'h3);
        bus_rd(1, v); chk("R8 irq readback", v, 8'h03);

        // R7 activate
        bus_wr(0, 8'h30); bus_wr(1, 8'h01);
        chk("R7 enable dev1", dev_en, 4'b0010);
        bus_rd(1, v); chk("R7 readback", v, 8'h01);
        bus_wr(1, 8'hFE);
        chk("R7 disable dev1", dev_en, 4'b0000);

        // R10 / R12 out-of-range selector
        bus_wr(0, 8'h07); bus_wr(1, 8'h09);
        bus_rd(1, v); chk("R12 selector readback", v, 8'h09);
        bus_wr(0, 8'h60);
        bus_rd(1, v); chk("R10 bank reads ff", v, 8'hFF);
        bus_wr(1, 8'h77);
        chk_outs("R10 write ignored");
        bus_wr(0, 8'h20);
        bus_rd(1, v); chk("R12 id with bad sel", v, 8'hC5);

        // R11 unknown register
        bus_wr(0, 8'h55);
        bus_rd(1, v); chk("R11 unknown reg", v, 8'hFF);

        // R4 lock and ignore writes
        bus_wr(0, 8'h07); bus_wr(1, 8'h01); bus_wr(0, 8'h61);
        bus_wr(0, K_OFF);
        bus_rd(1, v); chk("R4 locked data", v, 8'hFF);
        bus_rd(0, v); chk("R4 locked index", v, 8'hFF);
        bus_wr(1, 8'h12);
        chk("R4 base unchanged", dev_base[31:16], 16'h03F8);
        bus_wr(0, K_ON); bus_wr(0, K_ON);
        bus_rd(1, v); chk("R4 reopen keeps index", v, 8'hF8);

        // random mix, R5 reads and R6 outputs against the model
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 1) == 0)
                bus_wr(0, picks[$urandom_range(0, 9)]);
            else if ($urandom_range(0, 3) == 0)
                bus_wr(1, 8'($urandom_range(0, 5)));
            else
                bus_wr(1, 8'($urandom_range(0, 255)));
            chk_rd("R5 random index port", 0);
            chk_rd("R5 random data port", 1);
            chk_outs("R6 random outputs");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule